// File: doc/BRIEF.md
# Row-Sequenced Colour Bank Mapper

This block chooses, for each display line, which of three colour banks (A, B, C) feeds each of three interleaved output positions. It then delivers a gain factor per position: the 3-bit gain code of the bank assigned to that position, turned into a fixed factor. The data buses always go to the same physical channels. Only the bank that supplies each position's drive strength changes from line to line.

A 2-bit pattern select picks one of four line sequences. In stripe the assignment never changes. In interleaved mosaic it is rotated by one on every line. In mosaic it alternates between two arrangements. In diagonal it cycles through three arrangements. A line phase register steps once on every rising edge of the line latch. The pattern select is captured at that same edge, so a new pattern never takes effect part-way through a line. While standby is high, the line phase is held at its first value.

Top module: `rgb_row_bank_mapper`

## Requirements
- R1: With pattern 2'b11 captured, positions 1/2/3 show banks A/B/C (codes 0/1/2) on every line.
- R2: With pattern 2'b10 captured, successive lines repeat CAB, BCA, ABC, ... The arrangement for line phases 0/1/2 is ABC/CAB/BCA. A pattern change into 2'b10 steps the phase modulo 3.
- R3: With pattern 2'b01 captured, positions 1/2/3 show banks B/C/A (codes 1/2/0) on every line.
- R4: With pattern 2'b00 captured, lines alternate between ABC and BCA. The low bit of the phase selects the arrangement (0 gives ABC). The next phase is 1 when the low bit is 0, and 0 when it is 1.
- R5: The pattern select is sampled only at a rising edge of `line_latch`. A change of the pattern select at any other time has no effect on the bank outputs.
- R6: Each 0-to-1 transition of `line_latch`, sampled on a clock edge, advances the line phase exactly once, and the new banks are visible right after that edge. Holding `line_latch` high does not advance it again. The phase always stays within 0 to 2.
- R7: Reset sets line phase 0 and the stripe pattern. While `standby` is high, the line phase is forced to 0 one edge later and `line_latch` edges do not advance it. The captured pattern is kept.
- R8: The factor for each position comes from the gain code of the bank assigned to it. Codes 0 to 7 give 10, 12, 14, 16, 19, 22, 26 and 31. This path is combinational, so a gain change shows up in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_latch | input | 1 | Line latch; its rising edge starts a new line |
| standby | input | 1 | Holds the mapping at line phase 0 |
| pattern_sel | input | 2 | Pattern: 11 stripe, 10 diagonal, 01 interleaved mosaic, 00 mosaic |
| gain_a | input | 3 | Gain code of bank A |
| gain_b | input | 3 | Gain code of bank B |
| gain_c | input | 3 | Gain code of bank C |
| pos1_bank | output | 2 | Bank driving position 1 (0=A, 1=B, 2=C) |
| pos2_bank | output | 2 | Bank driving position 2 |
| pos3_bank | output | 2 | Bank driving position 3 |
| pos1_factor | output | 5 | Gain factor of position 1 |
| pos2_factor | output | 5 | Gain factor of position 2 |
| pos3_factor | output | 5 | Gain factor of position 3 |

## Verification
The bank outputs move exactly one clock edge after a latch rise or a standby level is presented. The bench drives inputs on the falling edge and advances its reference model for the rising edge that follows. It compares the outputs at the next falling edge. The gain factors carry no register, so they are checked in that same sample against the gain codes currently applied. This covers a gain change made mid-line. Directed steps hold the latch high, change the pattern with no edge, and toggle standby. Random steps with a fixed seed then mix all four patterns.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int NPOS   = 3;
  localparam int GAIN_W = 3;
  localparam int FACT_W = 5;
  localparam int BANK_W = 2;
  localparam int PH_W   = 2;

  typedef enum logic [1:0] {
    PAT_MOSAIC = 2'b00,
    PAT_ILV    = 2'b01,
    PAT_DIAG   = 2'b10,
    PAT_STRIPE = 2'b11
  } pat_e;

  // rotation: 0 = ABC, 1 = BCA, 2 = CAB
  function automatic logic [1:0] rot_of(pat_e p, logic [PH_W-1:0] ph);
    logic [1:0] r;
    case (p)
      PAT_STRIPE: r = 2'd0;
      PAT_ILV:    r = 2'd1;
      PAT_MOSAIC: r = ph[0] ? 2'd1 : 2'd0;
      default:    r = (ph == 2'd1) ? 2'd2 : ((ph == 2'd2) ? 2'd1 : 2'd0);
    endcase
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(int pos, logic [1:0] rot);
    int s;
    s = pos + int'(rot);
    if (s >= NPOS) s = s - NPOS;
    return BANK_W'(s);
  endfunction

  function automatic logic [PH_W-1:0] next_phase(pat_e p, logic [PH_W-1:0] ph);
    logic [PH_W-1:0] n;
    if (p == PAT_DIAG) n = (ph >= 2'd2) ? 2'd0 : ph + 2'd1;
    else               n = {1'b0, ~ph[0]};
    return n;
  endfunction

  function automatic logic [FACT_W-1:0] gain_factor(logic [GAIN_W-1:0] g);
    logic [FACT_W-1:0] f;
    case (g)
      3'd0: f = 5'd10;
      3'd1: f = 5'd12;
      3'd2: f = 5'd14;
      3'd3: f = 5'd16;
      3'd4: f = 5'd19;
      3'd5: f = 5'd22;
      3'd6: f = 5'd26;
      default: f = 5'd31;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/line_phase_seq.sv
module line_phase_seq
  import rbm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_latch,
  input  logic            standby,
  input  logic [1:0]      pattern_sel,
  output pat_e            act_pat,
  output logic [PH_W-1:0] phase,
  output logic            le_rise
);
  logic le_q;

  assign le_rise = line_latch & ~le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q    <= 1'b0;
      phase   <= '0;
      act_pat <= PAT_STRIPE;
    end else begin
      le_q <= line_latch;
      if (standby) begin
        phase <= '0;
      end else if (le_rise) begin
        act_pat <= pat_e'(pattern_sel);
        phase   <= next_phase(pat_e'(pattern_sel), phase);
      end
    end
  end

  // R6: phase never leaves 0..2
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 2'd2);

  // R5: without a latch rise neither phase nor pattern moves
  a_r5_pattern_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_rise && !standby) |=> ($stable(act_pat) && $stable(phase)));

  // R7: standby returns to line phase 0
  a_r7_standby_line1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (phase == 2'd0));
endmodule

// File: rtl/bank_rotator.sv
module bank_rotator
  import rbm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  pat_e                          act_pat,
  input  logic [PH_W-1:0]               phase,
  output logic [NPOS-1:0][BANK_W-1:0]   bank
);
  logic [1:0]      rot;
  logic [NPOS-1:0] used;

  assign rot = rot_of(act_pat, phase);

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    assign bank[i] = bank_of(i, rot);
  end

  always_comb begin
    used = '0;
    for (int i = 0; i < NPOS; i++) used[bank[i]] = 1'b1;
  end

  // R1: stripe always presents A/B/C
  a_r1_stripe: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pat == PAT_STRIPE) |-> (bank[0] == 2'd0 && bank[1] == 2'd1 && bank[2] == 2'd2));

  // R3: interleaved mosaic always presents B/C/A
  a_r3_ilv: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pat == PAT_ILV) |-> (bank[0] == 2'd1 && bank[1] == 2'd2 && bank[2] == 2'd0));

  // R2, R4: every arrangement uses each bank once
  a_r2_each_bank_once: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used) == NPOS);
endmodule

// File: rtl/gain_lut.sv
module gain_lut
  import rbm_pkg::*;
(
  input  logic [NPOS-1:0][GAIN_W-1:0] gains,
  input  logic [NPOS-1:0][BANK_W-1:0] bank,
  output logic [NPOS-1:0][FACT_W-1:0] factor
);
  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    logic [GAIN_W-1:0] sel;
    always_comb begin
      sel = '0;
      for (int b = 0; b < NPOS; b++)
        if (bank[i] == BANK_W'(b)) sel = gains[b];
    end
    assign factor[i] = gain_factor(sel);
  end
endmodule

// File: rtl/rgb_row_bank_mapper.sv
module rgb_row_bank_mapper
  import rbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_latch,
  input  logic        standby,
  input  logic [1:0]  pattern_sel,
  input  logic [2:0]  gain_a,
  input  logic [2:0]  gain_b,
  input  logic [2:0]  gain_c,
  output logic [1:0]  pos1_bank,
  output logic [1:0]  pos2_bank,
  output logic [1:0]  pos3_bank,
  output logic [4:0]  pos1_factor,
  output logic [4:0]  pos2_factor,
  output logic [4:0]  pos3_factor
);
  pat_e                        act_pat;
  logic [PH_W-1:0]             phase;
  logic                        le_rise;
  logic [NPOS-1:0][BANK_W-1:0] bank;
  logic [NPOS-1:0][GAIN_W-1:0] gains;
  logic [NPOS-1:0][FACT_W-1:0] factor;

  assign gains = {gain_c, gain_b, gain_a};

  line_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .line_latch(line_latch), .standby(standby),
    .pattern_sel(pattern_sel), .act_pat(act_pat), .phase(phase), .le_rise(le_rise)
  );

  bank_rotator u_rot (
    .clk(clk), .rst_n(rst_n), .act_pat(act_pat), .phase(phase), .bank(bank)
  );

  gain_lut u_lut (
    .gains(gains), .bank(bank), .factor(factor)
  );

  assign pos1_bank   = bank[0];
  assign pos2_bank   = bank[1];
  assign pos3_bank   = bank[2];
  assign pos1_factor = factor[0];
  assign pos2_factor = factor[1];
  assign pos3_factor = factor[2];

  // R8: factors stay within the table's span
  a_r8_factor_band: assert property (@(posedge clk) disable iff (!rst_n)
    (pos1_factor >= 5'd10) && (pos2_factor >= 5'd10) && (pos3_factor >= 5'd10));
endmodule

// File: tb/tb_rgb_row_bank_mapper.sv
module tb_rgb_row_bank_mapper;
  logic clk = 1'b0;
  logic rst_n;
  logic line_latch, standby;
  logic [1:0] pattern_sel;
  logic [2:0] gain_a, gain_b, gain_c;
  logic [1:0] pos1_bank, pos2_bank, pos3_bank;
  logic [4:0] pos1_factor, pos2_factor, pos3_factor;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] m_pat;
  logic [1:0] m_ph;
  logic       m_leq;

  always #5 clk = ~clk;

  rgb_row_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .line_latch(line_latch), .standby(standby),
    .pattern_sel(pattern_sel), .gain_a(gain_a), .gain_b(gain_b), .gain_c(gain_c),
    .pos1_bank(pos1_bank), .pos2_bank(pos2_bank), .pos3_bank(pos3_bank),
    .pos1_factor(pos1_factor), .pos2_factor(pos2_factor), .pos3_factor(pos3_factor)
  );

  // arrangement as {pos1,pos2,pos3}; A=0 B=1 C=2
  function automatic logic [5:0] exp_line(logic [1:0] p, logic [1:0] ph);
    logic [5:0] abc, bca, cab;
    abc = {2'd0, 2'd1, 2'd2};
    bca = {2'd1, 2'd2, 2'd0};
    cab = {2'd2, 2'd0, 2'd1};
    if (p == 2'b11) return abc;
    if (p == 2'b01) return bca;
    if (p == 2'b00) return (ph % 2 == 1) ? bca : abc;
    case (ph)
      2'd1:    return cab;
      2'd2:    return bca;
      default: return abc;
    endcase
  endfunction

  function automatic logic [1:0] exp_next(logic [1:0] p, logic [1:0] ph);
    if (p == 2'b10) return 2'((int'(ph) + 1) % 3);
    return (ph % 2 == 1) ? 2'd0 : 2'd1;
  endfunction

  function automatic int exp_factor(logic [2:0] g);
    int t[8] = '{10, 12, 14, 16, 19, 22, 26, 31};
    return t[g];
  endfunction

  function automatic logic [2:0] gain_for(logic [1:0] b);
    if (b == 2'd0) return gain_a;
    if (b == 2'd1) return gain_b;
    return gain_c;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag_in);
    logic [5:0] e;
    logic [1:0] eb[3];
    logic [1:0] ab[3];
    int         af[3];
    string      tag;
    e = exp_line(m_pat, m_ph);
    eb[0] = e[5:4]; eb[1] = e[3:2]; eb[2] = e[1:0];
    ab[0] = pos1_bank; ab[1] = pos2_bank; ab[2] = pos3_bank;
    af[0] = pos1_factor; af[1] = pos2_factor; af[2] = pos3_factor;
    if (tag_in != "") tag = tag_in;
    else case (m_pat)
      2'b11: tag = "R1";
      2'b10: tag = "R2";
      2'b01: tag = "R3";
      default: tag = "R4";
    endcase
    for (int i = 0; i < 3; i++) begin
      chk(ab[i] == eb[i], tag, $sformatf("bank pos%0d", i + 1), ab[i], eb[i]);
      chk(af[i] == exp_factor(gain_for(eb[i])), "R8", $sformatf("factor pos%0d", i + 1),
          af[i], exp_factor(gain_for(eb[i])));
    end
  endtask

  task automatic step(input logic le, input logic st, input logic [1:0] p,
                      input logic [2:0] ga, input logic [2:0] gb, input logic [2:0] gc,
                      input string tag);
    logic rise;
    line_latch = le; standby = st; pattern_sel = p;
    gain_a = ga; gain_b = gb; gain_c = gc;
    rise = le & ~m_leq;
    m_leq = le;
    if (st) m_ph = 2'd0;
    else if (rise) begin
      m_ph  = exp_next(p, m_ph);
      m_pat = p;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; line_latch = 1'b0; standby = 1'b0; pattern_sel = 2'b11;
    gain_a = 3'd0; gain_b = 3'd3; gain_c = 3'd7;
    m_pat = 2'b11; m_ph = 2'd0; m_leq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R7");

    // R1: stripe over several lines
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 2'b11, 3'd1, 3'd2, 3'd4, "R1");
      step(1'b0, 1'b0, 2'b11, 3'd1, 3'd2, 3'd4, "R1");
    end
    // R2: diagonal over six lines
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 2'b10, 3'd5, 3'd6, 3'd0, "R2");
      step(1'b0, 1'b0, 2'b10, 3'd5, 3'd6, 3'd0, "R2");
    end
    // R6: latch held high, no further advance
    step(1'b1, 1'b0, 2'b10, 3'd2, 3'd3, 3'd4, "R6");
    step(1'b1, 1'b0, 2'b10, 3'd2, 3'd3, 3'd4, "R6");
    step(1'b1, 1'b0, 2'b10, 3'd2, 3'd3, 3'd4, "R6");
    step(1'b0, 1'b0, 2'b10, 3'd2, 3'd3, 3'd4, "R6");
    // R5: pattern change without an edge
    step(1'b0, 1'b0, 2'b01, 3'd2, 3'd3, 3'd4, "R5");
    step(1'b0, 1'b0, 2'b00, 3'd2, 3'd3, 3'd4, "R5");
    // R3: interleaved mosaic
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 2'b01, 3'd7, 3'd1, 3'd3, "R3");
      step(1'b0, 1'b0, 2'b01, 3'd7, 3'd1, 3'd3, "R3");
    end
    // R4: mosaic
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 2'b00, 3'd6, 3'd4, 3'd2, "R4");
      step(1'b0, 1'b0, 2'b00, 3'd6, 3'd4, 3'd2, "R4");
    end
    // R7: standby forces line 1 and ignores latch edges
    step(1'b1, 1'b0, 2'b10, 3'd1, 3'd1, 3'd1, "R7");
    step(1'b0, 1'b1, 2'b10, 3'd1, 3'd1, 3'd1, "R7");
    step(1'b1, 1'b1, 2'b11, 3'd1, 3'd1, 3'd1, "R7");
    step(1'b0, 1'b1, 2'b11, 3'd1, 3'd1, 3'd1, "R7");
    step(1'b0, 1'b0, 2'b11, 3'd1, 3'd1, 3'd1, "R7");
    // R8: gain change mid-line, all codes
    for (int g = 0; g < 8; g++)
      step(1'b0, 1'b0, 2'b11, 3'(g), 3'(7 - g), 3'((g + 3) % 8), "R8");

    // random mix
    for (int k = 0; k < 600; k++) begin
      step(1'($urandom % 2), ($urandom % 16) == 0, 2'($urandom % 4),
           3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule